// File: doc/BRIEF.md
# CAN Receive Acceptance Sorter

The block sits behind a CAN frame decoder. Each time the decoder finishes a frame, it presents the identifier, the extended-ID flag, the RTR flag, the length code and the data. The decoder then pulses a completion strobe, or an abort strobe if an error cut the frame short. The sorter decides in the same cycle whether a receive buffer takes the frame. It then copies the whole record into the chosen buffer on the next clock edge.

Buffer 0 has priority and two acceptance filters. Buffer 1 has four acceptance filters. Each buffer has its own identifier mask and its own 2-bit receive mode. A full flag locks a loaded buffer against further loads until the host clears the flag. If the frame's destination is full and no rollover is possible, the frame is discarded and a sticky overflow flag is set. The host configures the block through a single-cycle write port. It selects which buffer appears on the read-out pins.

Top module: `can_rx_sorter`

## Requirements
- R1: Filter k holds an identifier and an extended-enable bit. It matches a frame when two conditions hold. First, the frame's extended flag equals the filter's extended-enable bit. Second, (frame id XOR filter id) AND mask is zero, using the mask of the filter's buffer. For a standard frame (ext=0) only id bits 10:0 take part in the compare; for an extended frame all 29 bits do.
- R2: Receive mode 01 admits only standard frames and mode 10 admits only extended frames, each still requiring a filter match. A filter whose extended-enable bit disagrees with the mode therefore never admits a frame.
- R3: Receive mode 11 admits every completed frame, with or without a filter match. A frame signalled by frm_abort is loaded only into a buffer whose mode is 11, including by rollover from buffer 0. In every other mode an aborted frame leaves the full flags, overflow flags and buffers unchanged.
- R4: Buffer 0's filters are filters 0–1 and buffer 1's filters are filters 2–5. If buffer 0 admits a frame, buffer 0 is the destination even when buffer 1 would also admit it. Each frame is loaded into at most one buffer. The stored hit field is the lowest-numbered matching filter of the admitting buffer, or 7 when none matches (possible only in mode 11).
- R5: A load overwrites the buffer's whole record: id, ext, rtr, dlc, all 64 data bits and hit. This holds for any dlc and either identifier type.
- R6: A load sets the buffer's full flag on the clock edge that latches the frame. A full buffer's contents and flag stay unchanged until the host writes address 9 with bit 0 (buffer 0) or bit 1 (buffer 1) set.
- R7: When control bit 4 (rollover) is set, a frame admitted by buffer 0 while buffer 0 is full goes into buffer 1 if buffer 1 is empty. This happens whatever buffer 1's filters say, and the hit field keeps buffer 0's value.
- R8: A frame that cannot be loaded is dropped. This happens when buffer 0 admits it while full and rollover is off or buffer 1 is full, or when only buffer 1 admits it while buffer 1 is full. The drop sets ovf[0] or ovf[1] respectively. The overflow flag stays set until the host writes address 9 with bit 2 or bit 3.
- R9: irq is high while some buffer is full and its interrupt enable is set: control bit 5 for buffer 0, control bit 6 for buffer 1.
- R10: Reset clears the full flags, overflow flags, filters, masks, control and both buffer records, so every read-out pin is zero.
- R11: A host write takes effect on the next clock edge. Addresses 0–5 load filter k: wdata[28:0] is the id and wdata[29] the extended-enable. Addresses 6 and 7 load the masks of buffers 0 and 1. Address 8 loads the control word: mode 0 in bits 1:0, mode 1 in bits 3:2, then rollover, ie0 and ie1. rd_sel selects buffer 0 (0) or buffer 1 (1) onto the read-out pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_done | input | 1 | Frame completed without error |
| frm_abort | input | 1 | Frame cut short by an error |
| frm_id | input | 29 | Assembled identifier |
| frm_ext | input | 1 | Extended identifier flag |
| frm_rtr | input | 1 | Remote request flag |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Data bytes |
| cfg_we | input | 1 | Host write strobe |
| cfg_addr | input | 4 | Host write address |
| cfg_wdata | input | 30 | Host write data |
| rd_sel | input | 1 | Buffer shown on read-out pins |
| rd_id | output | 29 | Stored identifier |
| rd_ext | output | 1 | Stored extended flag |
| rd_rtr | output | 1 | Stored remote request flag |
| rd_dlc | output | 4 | Stored length code |
| rd_data | output | 64 | Stored data |
| rd_hit | output | 3 | Index of the filter that matched |
| full | output | 2 | Full flags per buffer |
| ovf | output | 2 | Sticky overflow flags per buffer |
| irq | output | 1 | Receive interrupt |

## Verification
The bench builds the block with its default parameters: 29-bit extended identifiers, 11-bit standard identifiers and eight data bytes. With these values, the 11-bit truncation of standard compares can be reached with frames that carry stray upper identifier bits. The full 64-bit data overwrite can be seen after a short-dlc frame. Random masks with cleared bits bring wildcard matches within reach. Random control words reach every pairing of receive modes, with rollover and interrupt enables on and off.

// File: rtl/can_rx_sorter.sv
module can_rx_sorter #(
  parameter int ID_W   = 29,
  parameter int SID_W  = 11,
  parameter int NBYTES = 8,
  localparam int DW    = NBYTES * 8,
  localparam int CW    = ID_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frm_done,
  input  logic            frm_abort,
  input  logic [ID_W-1:0] frm_id,
  input  logic            frm_ext,
  input  logic            frm_rtr,
  input  logic [3:0]      frm_dlc,
  input  logic [DW-1:0]   frm_data,
  input  logic            cfg_we,
  input  logic [3:0]      cfg_addr,
  input  logic [CW-1:0]   cfg_wdata,
  input  logic            rd_sel,
  output logic [ID_W-1:0] rd_id,
  output logic            rd_ext,
  output logic            rd_rtr,
  output logic [3:0]      rd_dlc,
  output logic [DW-1:0]   rd_data,
  output logic [2:0]      rd_hit,
  output logic [1:0]      full,
  output logic [1:0]      ovf,
  output logic            irq
);

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            ext;
    logic            rtr;
    logic [3:0]      dlc;
    logic [DW-1:0]   data;
    logic [2:0]      hit;
  } rec_t;

  localparam logic [ID_W-1:0] STD_BITS = {{(ID_W-SID_W){1'b0}}, {SID_W{1'b1}}};

  logic [ID_W-1:0] flt_id [6];
  logic [5:0]      flt_x;
  logic [ID_W-1:0] msk0, msk1;
  logic [6:0]      ctrl;
  rec_t            slot0, slot1;

  wire [1:0] mode0 = ctrl[1:0];
  wire [1:0] mode1 = ctrl[3:2];
  wire       roll  = ctrl[4];
  wire [1:0] ie    = ctrl[6:5];

  wire [ID_W-1:0] em0 = frm_ext ? msk0 : (msk0 & STD_BITS);
  wire [ID_W-1:0] em1 = frm_ext ? msk1 : (msk1 & STD_BITS);

  logic [5:0] fm;
  always_comb
    for (int f = 0; f < 6; f++)
      fm[f] = (((frm_id ^ flt_id[f]) & ((f < 2) ? em0 : em1)) == '0) && (frm_ext == flt_x[f]);

  wire ok0 = (mode0 == 2'd0) | ((mode0 == 2'd1) & ~frm_ext) | ((mode0 == 2'd2) & frm_ext);
  wire ok1 = (mode1 == 2'd0) | ((mode1 == 2'd1) & ~frm_ext) | ((mode1 == 2'd2) & frm_ext);

  wire evt  = frm_done | frm_abort;
  wire acc0 = (mode0 == 2'd3) | (~frm_abort & ok0 & |fm[1:0]);
  wire acc1 = (mode1 == 2'd3) | (~frm_abort & ok1 & |fm[5:2]);

  wire [2:0] hit0 = fm[0] ? 3'd0 : fm[1] ? 3'd1 : 3'd7;
  wire [2:0] hit1 = fm[2] ? 3'd2 : fm[3] ? 3'd3 : fm[4] ? 3'd4 : fm[5] ? 3'd5 : 3'd7;

  wire spill = acc0 & full[0] & roll & ~full[1];
  wire ld0   = evt & acc0 & ~full[0];
  wire ld1   = evt & (spill | (~acc0 & acc1 & ~full[1]));
  wire sov0  = evt & acc0 & full[0] & ~spill;
  wire sov1  = evt & ~acc0 & acc1 & full[1];

  wire [3:0] clr = (cfg_we && cfg_addr == 4'd9) ? cfg_wdata[3:0] : 4'd0;

  rec_t inc;
  assign inc = '{id: frm_id, ext: frm_ext, rtr: frm_rtr, dlc: frm_dlc, data: frm_data,
                 hit: acc0 ? hit0 : hit1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < 6; f++) flt_id[f] <= '0;
      flt_x <= '0;
      msk0  <= '0;
      msk1  <= '0;
      ctrl  <= '0;
      full  <= '0;
      ovf   <= '0;
      slot0 <= '0;
      slot1 <= '0;
    end else begin
      for (int f = 0; f < 6; f++)
        if (cfg_we && cfg_addr == 4'(f)) begin
          flt_id[f] <= cfg_wdata[ID_W-1:0];
          flt_x[f]  <= cfg_wdata[ID_W];
        end
      if (cfg_we && cfg_addr == 4'd6) msk0 <= cfg_wdata[ID_W-1:0];
      if (cfg_we && cfg_addr == 4'd7) msk1 <= cfg_wdata[ID_W-1:0];
      if (cfg_we && cfg_addr == 4'd8) ctrl <= cfg_wdata[6:0];
      full <= (full & ~clr[1:0]) | {ld1, ld0};
      ovf  <= (ovf & ~clr[3:2]) | {sov1, sov0};
      if (ld0) slot0 <= inc;
      if (ld1) slot1 <= inc;
    end
  end

  rec_t shown;
  assign shown   = rd_sel ? slot1 : slot0;
  assign rd_id   = shown.id;
  assign rd_ext  = shown.ext;
  assign rd_rtr  = shown.rtr;
  assign rd_dlc  = shown.dlc;
  assign rd_data = shown.data;
  assign rd_hit  = shown.hit;
  assign irq     = |(full & ie);

endmodule

module can_rx_sorter_chk #(parameter int CW = 30) (
  input logic          clk,
  input logic          rst_n,
  input logic          frm_done,
  input logic          frm_abort,
  input logic          cfg_we,
  input logic [3:0]    cfg_addr,
  input logic [CW-1:0] cfg_wdata,
  input logic [6:0]    ctrl,
  input logic [1:0]    full,
  input logic [1:0]    ovf,
  input logic          irq
);
  wire wclr = cfg_we && cfg_addr == 4'd9;

  AST_FULL_HOLD0: assert property (@(posedge clk) disable iff (!rst_n)
    full[0] && !(wclr && cfg_wdata[0]) |=> full[0]); // R6
  AST_FULL_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
    full[1] && !(wclr && cfg_wdata[1]) |=> full[1]); // R6
  AST_FULL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full[0]) |-> $past(frm_done || frm_abort)); // R6
  AST_ABORT_DEBUG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full[0]) && $past(frm_abort) && !$past(frm_done) |-> $past(ctrl[1:0]) == 2'b11); // R3
  AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(full[0]) && $rose(full[1]))); // R4
  AST_OVF_STICKY0: assert property (@(posedge clk) disable iff (!rst_n)
    ovf[0] && !(wclr && cfg_wdata[2]) |=> ovf[0]); // R8
  AST_OVF_STICKY1: assert property (@(posedge clk) disable iff (!rst_n)
    ovf[1] && !(wclr && cfg_wdata[3]) |=> ovf[1]); // R8
  AST_IRQ_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full[0]) && ctrl[5] |-> irq); // R9
endmodule

bind can_rx_sorter can_rx_sorter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_abort(frm_abort),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ctrl(ctrl),
  .full(full), .ovf(ovf), .irq(irq));

// File: tb/test_can_rx_sorter.sv
`timescale 1ns/1ps
module test_can_rx_sorter;
  logic clk = 0, rst_n = 0;
  logic frm_done = 0, frm_abort = 0, frm_ext = 0, frm_rtr = 0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = '0;
  logic [29:0] cfg_wdata = '0;
  logic rd_sel = 0;
  logic [28:0] rd_id;
  logic rd_ext, rd_rtr, irq;
  logic [3:0] rd_dlc;
  logic [63:0] rd_data;
  logic [2:0] rd_hit;
  logic [1:0] full, ovf;

  can_rx_sorter i_can_rx_sorter (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [28:0] m_fid [6];
  logic [5:0]  m_fx;
  logic [28:0] m_msk [2];
  logic [6:0]  m_ctl;
  logic [1:0]  m_full, m_ovf;
  logic [28:0] m_id [2];
  logic [1:0]  m_ext, m_rtr;
  logic [3:0]  m_dlc [2];
  logic [63:0] m_dat [2];
  logic [2:0]  m_hit [2];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " full"}, 64'(full), 64'(m_full));
    chk({tag, " ovf"}, 64'(ovf), 64'(m_ovf));
    chk({tag, " irq R9"}, 64'(irq), 64'(|(m_full & m_ctl[6:5])));
    for (int b = 0; b < 2; b++) begin
      rd_sel = b[0];
      #0.2;
      chk({tag, " id"}, 64'(rd_id), 64'(m_id[b]));
      chk({tag, " flags"}, {62'd0, rd_ext, rd_rtr}, {62'd0, m_ext[b], m_rtr[b]});
      chk({tag, " dlc"}, 64'(rd_dlc), 64'(m_dlc[b]));
      chk({tag, " data R5"}, rd_data, m_dat[b]);
      chk({tag, " hit R4"}, 64'(rd_hit), 64'(m_hit[b]));
    end
  endtask

  function automatic bit hits(int k, logic [28:0] id, logic ext);
    logic [28:0] m;
    m = m_msk[k < 2 ? 0 : 1];
    if (!ext) m = m & 29'h7FF;
    return (ext == m_fx[k]) && (((id ^ m_fid[k]) & m) == 0);
  endfunction

  function automatic bit mode_ok(logic [1:0] md, logic ext);
    case (md)
      2'd0: return 1;
      2'd1: return !ext;
      2'd2: return ext;
      default: return 0;
    endcase
  endfunction

  task automatic wr(input logic [3:0] a, input logic [29:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a < 6) begin m_fid[a] = d[28:0]; m_fx[a] = d[29]; end
    else if (a == 6) m_msk[0] = d[28:0];
    else if (a == 7) m_msk[1] = d[28:0];
    else if (a == 8) m_ctl = d[6:0];
    else if (a == 9) begin m_full &= ~d[1:0]; m_ovf &= ~d[3:2]; end
  endtask

  task automatic put(int b, logic [28:0] id, logic ext, logic rtr, logic [3:0] dlc,
                     logic [63:0] dat, logic [2:0] h);
    m_full[b] = 1; m_id[b] = id; m_ext[b] = ext; m_rtr[b] = rtr;
    m_dlc[b] = dlc; m_dat[b] = dat; m_hit[b] = h;
  endtask

  task automatic send(input logic [28:0] id, input logic ext, input logic rtr,
                      input logic [3:0] dlc, input logic [63:0] dat, input bit ab,
                      input string tag);
    logic [2:0] h0, h1;
    bit a0, a1;
    @(negedge clk);
    frm_id = id; frm_ext = ext; frm_rtr = rtr; frm_dlc = dlc; frm_data = dat;
    frm_done = !ab; frm_abort = ab;
    @(negedge clk);
    frm_done = 0; frm_abort = 0;
    h0 = 7; h1 = 7;
    for (int k = 5; k >= 2; k--) if (hits(k, id, ext)) h1 = 3'(k);
    for (int k = 1; k >= 0; k--) if (hits(k, id, ext)) h0 = 3'(k);
    if (m_ctl[1:0] == 3) a0 = 1;
    else a0 = !ab && mode_ok(m_ctl[1:0], ext) && h0 != 7;
    if (m_ctl[3:2] == 3) a1 = 1;
    else a1 = !ab && mode_ok(m_ctl[3:2], ext) && h1 != 7;
    if (a0) begin
      if (!m_full[0]) put(0, id, ext, rtr, dlc, dat, h0);
      else if (m_ctl[4] && !m_full[1]) put(1, id, ext, rtr, dlc, dat, h0);
      else m_ovf[0] = 1;
    end else if (a1) begin
      if (!m_full[1]) put(1, id, ext, rtr, dlc, dat, h1);
      else m_ovf[1] = 1;
    end
    check_all(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 6; k++) begin m_fid[k] = '0; end
    m_fx = '0; m_msk[0] = '0; m_msk[1] = '0; m_ctl = '0; m_full = '0; m_ovf = '0;
    for (int b = 0; b < 2; b++) begin
      m_id[b] = '0; m_dlc[b] = '0; m_dat[b] = '0; m_hit[b] = '0;
    end
    m_ext = '0; m_rtr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R10 reset");

    wr(0, {1'b0, 29'h123});
    wr(1, {1'b1, 29'h1ABCDEF0});
    wr(2, {1'b0, 29'h456});
    wr(3, {1'b1, 29'h0000_777});
    wr(4, {1'b0, 29'h7FF});
    wr(5, {1'b0, 29'h000});
    wr(6, {1'b0, {29{1'b1}}});
    wr(7, {1'b0, {29{1'b1}}});
    wr(8, 30'h60);
    check_all("R11 config");

    send(29'h123, 0, 0, 4'd8, 64'h0102030405060708, 0, "R1 std match buf0");
    send(29'h456, 0, 1, 4'd1, 64'hAA, 0, "R4 buf1 hit2");
    send(29'h123, 0, 0, 4'd2, 64'hBEEF, 0, "R8 overflow buf0 R6 lockout");
    wr(9, 30'h5);
    check_all("R6 clear full0 R8 clear ovf0");
    send(29'h1FFFF123, 0, 0, 4'd0, 64'h0, 0, "R1 std 11-bit compare R5 overwrite");
    wr(9, 30'h3);
    send(29'h123, 1, 0, 4'd3, 64'h55, 0, "R1 ext flag mismatch");
    wr(6, {1'b0, 29'h1FFFFFF0});
    send(29'h12A, 0, 0, 4'd4, 64'h1234, 0, "R1 mask wildcard");
    wr(8, 30'h70);
    send(29'h1ABCDEF0, 1, 0, 4'd5, 64'hFEED, 0, "R7 rollover into buf1");
    wr(9, 30'h3);
    wr(8, 30'h01);
    send(29'h1ABCDEF0, 1, 0, 4'd5, 64'h99, 0, "R2 std-only mode rejects ext");
    wr(8, 30'h02);
    send(29'h123, 0, 0, 4'd5, 64'h98, 0, "R2 ext-only mode rejects std");
    send(29'h0000_777, 1, 0, 4'd5, 64'h97, 0, "R2 ext frame to buf1");
    wr(9, 30'h3);
    send(29'h456, 0, 0, 4'd1, 64'h11, 1, "R3 abort ignored in mode 00");
    wr(8, 30'h0C);
    send(29'h0ABCDE, 1, 1, 4'd3, 64'h22, 1, "R3 abort captured in mode 11");
    send(29'h123, 0, 0, 4'd1, 64'h33, 0, "R4 buf0 wins");
    wr(8, 30'h00);
    check_all("R9 irq disabled");

    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom % 20;
      if (r < 3) wr(9, 30'($urandom % 16));
      else if (r == 3) begin
        logic [6:0] c;
        c = 7'($urandom);
        if (c[1:0] == 3 && $urandom % 2) c[1:0] = 0;
        if (c[3:2] == 3 && $urandom % 2) c[3:2] = 0;
        wr(8, 30'(c));
      end else if (r == 4) wr(4'($urandom % 6), 30'($urandom));
      else if (r == 5) wr(4'(6 + $urandom % 2), {1'b0, 29'($urandom | $urandom)});
      else begin
        int k;
        logic [28:0] id;
        logic ext;
        k = $urandom % 6;
        ext = ($urandom % 4 == 0) ? !m_fx[k] : m_fx[k];
        id = m_fid[k] ^ (29'($urandom) & ~m_msk[k < 2 ? 0 : 1]);
        if ($urandom % 4 == 0) id = 29'($urandom);
        send(id, ext, 1'($urandom), 4'($urandom), {$urandom, $urandom},
             ($urandom % 10 == 0), "R1 R2 R3 R4 R7 R8 random");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule